// File: doc/BRIEF.md
# Radix-3 SAR Capacitor Mismatch Calibration and Correction Engine

This block sits beside the switch logic of a radix-3 successive-approximation converter and removes the error caused by mismatched MSB capacitors. On request it runs a foreground calibration. The capacitor array is treated as `N_CAP` capacitors. The lowest `Q_LSB` of them are taken as ideal. Each higher capacitor is measured in turn, from the top one down. A measurement charges the capacitor under test to the reference, then redistributes that charge against the lower calibrated capacitors. The block then reads the resulting residue through the two comparator outputs, using a ternary search over the LSB capacitors only.

Each measured residue becomes a signed error term held in half-LSB units. Every term depends on the terms already found for the capacitors above it. Once calibration is done, each normal conversion result is presented with the final switch setting of every MSB capacitor. The block subtracts the summed correction from the raw binary result, saturates the difference, and returns it one cycle later. The analog residue is outside the block and is seen only as the comparator results.

Top module: `r3cal_engine`

## Requirements
- R1: After reset `cal_busy`, `cal_done` and `out_valid` are 0, every capacitor switch code on `dac_sw` is common mode, and all error terms are zero, so a conversion returns its raw value unchanged. Switch codes are 2 bits per capacitor: 00 ground, 01 common mode, 10 reference. Capacitor k (1-based) uses bits [2k-1:2k-2].
- R2: A `cal_start` seen while idle makes `cal_busy` 1 from the next cycle and clears `cal_done`. A `cal_start` seen while busy has no effect on timing or results.
- R3: Calibration visits capacitors `N_CAP` down to `Q_LSB+1`, spending `Q_LSB+3` cycles on each: one precharge cycle, one redistribution cycle, `Q_LSB` quantize cycles and one update cycle. `cal_busy` drops right after the last update.
- R4: In the precharge cycle the capacitor under test is at reference and every other capacitor is at common mode. While idle, all capacitors are at common mode.
- R5: In the redistribution cycle the capacitors from `Q_LSB+1` up to just below the one under test are at reference. The capacitor under test and all LSB capacitors are at ground, and the capacitors above it are at common mode.
- R6: Quantize step s (0 first) samples the comparators at the end of its cycle. `cmp_up` alone gives +1, `cmp_dn` alone gives -1, and neither or both give 0. The digit is weighted by 3^(Q_LSB-1-s). From the next cycle, LSB capacitor Q_LSB-s shows that digit as reference, ground or common mode.
- R7: The error of the capacitor under test, in half-LSB units, is the quantized residue minus floor(S/2), where S is the sum, in half-LSB units, of the errors already found for the capacitors above it.
- R8: For a conversion, the 2-bit slice j of `conv_sw` gives the final setting of capacitor `Q_LSB+1+j`. A reference setting adds twice that capacitor's stored term to a quarter-LSB accumulator C, common mode adds it once, and ground adds nothing.
- R9: A conversion accepted while idle gives `out_valid` in the next cycle. `out_data` = raw - floor((C+2)/4), saturated to 0 and 2^RAW_W-1.
- R10: A conversion presented while `cal_busy` is 1 produces no `out_valid`.
- R11: `cal_done` rises when calibration ends and stays 1 until the next accepted `cal_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Request to start a calibration run |
| cmp_up | input | 1 | Comparator: residue above upper threshold |
| cmp_dn | input | 1 | Comparator: residue below lower threshold |
| dac_sw | output | 2*N_CAP | Switch code for every capacitor during calibration |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Calibration completed, sticky |
| conv_valid | input | 1 | Raw conversion result present |
| conv_raw | input | RAW_W | Raw binary conversion result |
| conv_sw | input | 2*(N_CAP-Q_LSB) | Final switch setting of each MSB capacitor |
| out_valid | output | 1 | Corrected result valid |
| out_data | output | RAW_W | Corrected, saturated result |

## Verification
The bench feeds two calibration runs with chosen comparator digits. One run includes the case where both comparators fire, which is read as zero; a design that decoded it otherwise would skew the residue. The bench then isolates each stored term by turning on one capacitor at a time at reference. A wrong sign or rounding in the recursive floor(S/2) term would show as an off-by-one on a lower capacitor. The switch codes are compared in every precharge and redistribution cycle, and a swapped ground/reference choice would appear there. The bench also drives results at both ends of the range to show saturation, and sends requests and conversions during a run to confirm that they are ignored and blocked.

// File: rtl/r3cal_pkg.sv
package r3cal_pkg;

    typedef enum logic [1:0] {
        SW_GND = 2'b00,
        SW_CM  = 2'b01,
        SW_REF = 2'b10
    } sw_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_RED,
        ST_QNT,
        ST_UPD
    } cal_st_e;

    // 3 to the power e, e limited to a small range
    function automatic int pow3(input int e);
        int r;
        r = 1;
        for (int i = 0; i < 20; i++) begin
            if (i < e) r = r * 3;
        end
        return r;
    endfunction

endpackage

// File: rtl/r3cal_trit.sv
module r3cal_trit
    import r3cal_pkg::*;
(
    input  logic              up,
    input  logic              dn,
    output logic signed [1:0] trit,
    output logic [1:0]        code
);
    always_comb begin
        if (up && !dn) begin
            trit = 2'sd1;
            code = SW_REF;
        end else if (dn && !up) begin
            trit = -2'sd1;
            code = SW_GND;
        end else begin
            trit = 2'sd0;
            code = SW_CM;
        end
    end
endmodule

// File: rtl/r3cal_seq.sv
module r3cal_seq
    import r3cal_pkg::*;
#(
    parameter int N_CAP = 7,
    parameter int Q_LSB = 3,
    parameter int ERR_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cal_start,
    input  logic                         cmp_up,
    input  logic                         cmp_dn,
    output logic [2*N_CAP-1:0]           dac_sw,
    output logic                         busy,
    output logic                         done,
    output logic [(N_CAP-Q_LSB)*ERR_W-1:0] err_flat
);
    localparam int M     = N_CAP - Q_LSB;
    localparam int CPW   = (M > 1) ? $clog2(M) : 1;
    localparam int STW   = (Q_LSB > 1) ? $clog2(Q_LSB) : 1;
    localparam int SUM_W = ERR_W + 4;

    typedef struct packed {
        cal_st_e                    st;
        logic [CPW-1:0]             cap;
        logic [STW-1:0]             step;
        logic signed [ERR_W-1:0]    resid;
        logic signed [SUM_W-1:0]    ssum;
        logic                       done;
        logic [M-1:0][ERR_W-1:0]    err;
        logic [Q_LSB-1:0][1:0]      lsb;
    } seq_t;

    seq_t q, d;

    logic signed [1:0]       trit;
    logic [1:0]              tcode;
    logic signed [ERR_W-1:0] eh;
    int                      w;

    r3cal_trit u_trit (
        .up   (cmp_up),
        .dn   (cmp_dn),
        .trit (trit),
        .code (tcode)
    );

    always_comb begin
        d  = q;
        w  = pow3(Q_LSB - 1 - int'(q.step));
        eh = q.resid - ERR_W'(q.ssum >>> 1);
        case (q.st)
            ST_IDLE: begin
                if (cal_start) begin
                    d.st   = ST_PRE;
                    d.cap  = CPW'(M - 1);
                    d.ssum = '0;
                    d.done = 1'b0;
                end
            end
            ST_PRE: d.st = ST_RED;
            ST_RED: begin
                d.st    = ST_QNT;
                d.step  = '0;
                d.resid = '0;
                for (int k = 0; k < Q_LSB; k++) d.lsb[k] = SW_CM;
            end
            ST_QNT: begin
                d.resid = q.resid + ERR_W'(int'(trit) * w);
                d.lsb[Q_LSB-1-int'(q.step)] = tcode;
                if (q.step == STW'(Q_LSB - 1)) d.st = ST_UPD;
                else d.step = q.step + 1'b1;
            end
            ST_UPD: begin
                d.err[q.cap] = eh;
                d.ssum       = q.ssum + SUM_W'(eh);
                if (q.cap == '0) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.cap = q.cap - 1'b1;
                    d.st  = ST_PRE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.cap   <= '0;
            q.step  <= '0;
            q.resid <= '0;
            q.ssum  <= '0;
            q.done  <= 1'b0;
            q.err   <= '0;
            for (int k = 0; k < Q_LSB; k++) q.lsb[k] <= SW_CM;
        end else begin
            q <= d;
        end
    end

    // switch codes driven from the current phase
    always_comb begin
        dac_sw = '0;
        for (int i = 0; i < N_CAP; i++) begin
            logic [1:0] c;
            c = SW_CM;
            case (q.st)
                ST_PRE: begin
                    if (i == Q_LSB + int'(q.cap)) c = SW_REF;
                end
                ST_RED, ST_QNT: begin
                    if (i < Q_LSB)
                        c = (q.st == ST_RED) ? SW_GND : q.lsb[i];
                    else if (i < Q_LSB + int'(q.cap))
                        c = SW_REF;
                    else if (i == Q_LSB + int'(q.cap))
                        c = SW_GND;
                end
                default: c = SW_CM;
            endcase
            dac_sw[2*i +: 2] = c;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign err_flat = q.err;

endmodule

// File: rtl/r3cal_corr.sv
module r3cal_corr
    import r3cal_pkg::*;
#(
    parameter int N_CAP = 7,
    parameter int Q_LSB = 3,
    parameter int ERR_W = 12,
    parameter int RAW_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [RAW_W-1:0]               raw,
    input  logic [2*(N_CAP-Q_LSB)-1:0]     sw,
    input  logic [(N_CAP-Q_LSB)*ERR_W-1:0] err_flat,
    output logic                           out_valid,
    output logic [RAW_W-1:0]               out_data
);
    localparam int M     = N_CAP - Q_LSB;
    localparam int ACC_W = ERR_W + 8;
    localparam int D_W   = ((RAW_W > ACC_W) ? RAW_W : ACC_W) + 2;

    typedef struct packed {
        logic             vld;
        logic [RAW_W-1:0] dat;
    } out_t;

    out_t q, d;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] corr;
    logic signed [D_W-1:0]   diff;
    logic signed [D_W-1:0]   maxv;

    always_comb begin
        acc = '0;
        for (int j = 0; j < M; j++) begin
            logic signed [ERR_W-1:0] e;
            logic signed [ACC_W-1:0] ev;
            e  = $signed(err_flat[j*ERR_W +: ERR_W]);
            ev = ACC_W'(e);
            case (sw[2*j +: 2])
                SW_REF:  acc = acc + (ev <<< 1);
                SW_CM:   acc = acc + ev;
                default: acc = acc;
            endcase
        end
        corr = (acc + ACC_W'(2)) >>> 2;
        diff = D_W'($signed({1'b0, raw})) - D_W'(corr);
        maxv = $signed({{(D_W-RAW_W){1'b0}}, {RAW_W{1'b1}}});

        d.vld = in_valid;
        d.dat = q.dat;
        if (in_valid) begin
            if (diff < 0)         d.dat = '0;
            else if (diff > maxv) d.dat = {RAW_W{1'b1}};
            else                  d.dat = diff[RAW_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.vld <= 1'b0;
            q.dat <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.vld;
    assign out_data  = q.dat;

endmodule

// File: rtl/r3cal_engine.sv
module r3cal_engine
    import r3cal_pkg::*;
#(
    parameter int N_CAP = 7,
    parameter int Q_LSB = 3,
    parameter int ERR_W = 12,
    parameter int RAW_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cal_start,
    input  logic                       cmp_up,
    input  logic                       cmp_dn,
    output logic [2*N_CAP-1:0]         dac_sw,
    output logic                       cal_busy,
    output logic                       cal_done,
    input  logic                       conv_valid,
    input  logic [RAW_W-1:0]           conv_raw,
    input  logic [2*(N_CAP-Q_LSB)-1:0] conv_sw,
    output logic                       out_valid,
    output logic [RAW_W-1:0]           out_data
);
    localparam int M = N_CAP - Q_LSB;

    logic [M*ERR_W-1:0] err_flat;
    logic               busy;

    r3cal_seq #(.N_CAP(N_CAP), .Q_LSB(Q_LSB), .ERR_W(ERR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_start (cal_start),
        .cmp_up    (cmp_up),
        .cmp_dn    (cmp_dn),
        .dac_sw    (dac_sw),
        .busy      (busy),
        .done      (cal_done),
        .err_flat  (err_flat)
    );

    r3cal_corr #(.N_CAP(N_CAP), .Q_LSB(Q_LSB), .ERR_W(ERR_W), .RAW_W(RAW_W)) u_corr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (conv_valid && !busy),
        .raw       (conv_raw),
        .sw        (conv_sw),
        .err_flat  (err_flat),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign cal_busy = busy;

endmodule

// File: rtl/r3cal_engine_chk.sv
module r3cal_engine_chk #(
    parameter int N_CAP = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cal_start,
    input logic               conv_valid,
    input logic [2*N_CAP-1:0] dac_sw,
    input logic               cal_busy,
    input logic               cal_done,
    input logic               out_valid
);
    assert_idle_cm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_busy |-> dac_sw == {N_CAP{2'b01}});

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_start && !cal_busy) |=> (cal_busy && !cal_done));

    assert_conv_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && !cal_busy) |=> out_valid);

    assert_block_conv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && cal_busy) |=> !out_valid);

    assert_done_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> cal_done);

    assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !cal_start) |=> cal_done);

    assert_busy_done_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_busy && cal_done));
endmodule

bind r3cal_engine r3cal_engine_chk #(.N_CAP(N_CAP)) u_chk (.*);

// File: tb/r3cal_engine_tb.sv
module r3cal_engine_tb;
    localparam int N_CAP = 7;
    localparam int Q_LSB = 3;
    localparam int ERR_W = 12;
    localparam int RAW_W = 12;
    localparam int M     = N_CAP - Q_LSB;
    localparam int P     = Q_LSB + 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cal_start = 1'b0;
    logic               cmp_up = 1'b0;
    logic               cmp_dn = 1'b0;
    logic [2*N_CAP-1:0] dac_sw;
    logic               cal_busy;
    logic               cal_done;
    logic               conv_valid = 1'b0;
    logic [RAW_W-1:0]   conv_raw = '0;
    logic [2*M-1:0]     conv_sw = '0;
    logic               out_valid;
    logic [RAW_W-1:0]   out_data;

    int n_chk  = 0;
    int n_fail = 0;
    int tr     [M][Q_LSB];
    int exp_eh [M];

    always #2 clk = ~clk;

    r3cal_engine #(.N_CAP(N_CAP), .Q_LSB(Q_LSB), .ERR_W(ERR_W), .RAW_W(RAW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cmp_up(cmp_up), .cmp_dn(cmp_dn),
        .dac_sw(dac_sw), .cal_busy(cal_busy), .cal_done(cal_done), .conv_valid(conv_valid),
        .conv_raw(conv_raw), .conv_sw(conv_sw), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    function automatic int p3(input int e);
        int r;
        r = 1;
        for (int i = 0; i < e; i++) r = r * 3;
        return r;
    endfunction

    function automatic int tval(input int t);
        return (t == 1) ? 1 : (t == -1) ? -1 : 0;
    endfunction

    function automatic int tcode(input int t);
        return (t == 1) ? 2 : (t == -1) ? 0 : 1;
    endfunction

    task automatic model_cal();
        int s;
        s = 0;
        for (int j = M - 1; j >= 0; j--) begin
            int r;
            r = 0;
            for (int k = 0; k < Q_LSB; k++) r += tval(tr[j][k]) * p3(Q_LSB - 1 - k);
            exp_eh[j] = r - (s >>> 1);
            s += exp_eh[j];
        end
    endtask

    task automatic run_cal(input bit inject);
        model_cal();
        @(negedge clk);
        cal_start = 1'b1;
        @(posedge clk);
        for (int j = M - 1; j >= 0; j--) begin
            for (int c = 0; c < P; c++) begin
                logic [2*N_CAP-1:0] ed;
                @(negedge clk);
                if (j == M - 1 && c == 0) begin
                    cal_start = 1'b0;
                    chk(cal_busy == 1'b1, "R2 busy after start", cal_busy, 1);
                    chk(cal_done == 1'b0, "R11 done cleared by start", cal_done, 0);
                end
                if (c == 0) begin
                    for (int i = 0; i < N_CAP; i++) ed[2*i +: 2] = (i == Q_LSB + j) ? 2'b10 : 2'b01;
                    chk(dac_sw == ed, "R4 precharge codes", dac_sw, ed);
                end
                if (c == 1) begin
                    for (int i = 0; i < N_CAP; i++)
                        ed[2*i +: 2] = (i < Q_LSB) ? 2'b00 : (i < Q_LSB + j) ? 2'b10 :
                                       (i == Q_LSB + j) ? 2'b00 : 2'b01;
                    chk(dac_sw == ed, "R5 redistribution codes", dac_sw, ed);
                    if (inject && j == M - 1) begin
                        cal_start  = 1'b1;
                        conv_valid = 1'b1;
                        conv_raw   = 12'd100;
                    end
                end
                if (c == 2 && inject && j == M - 1) begin
                    chk(out_valid == 1'b0, "R10 conversion blocked", out_valid, 0);
                    cal_start  = 1'b0;
                    conv_valid = 1'b0;
                end
                if (c == 3)
                    chk(dac_sw[2*(Q_LSB-1) +: 2] == 2'(tcode(tr[j][0])), "R6 LSB digit code",
                        dac_sw[2*(Q_LSB-1) +: 2], tcode(tr[j][0]));
                if (c == P - 1 && j == 0)
                    chk(cal_busy == 1'b1, "R3 busy in last update", cal_busy, 1);
                if (c >= 2 && c < 2 + Q_LSB) begin
                    int t;
                    t = tr[j][c-2];
                    cmp_up = (t == 1 || t == 2);
                    cmp_dn = (t == -1 || t == 2);
                end else begin
                    cmp_up = 1'b0;
                    cmp_dn = 1'b0;
                end
                @(posedge clk);
            end
        end
        @(negedge clk);
        chk(cal_busy == 1'b0, "R3 busy ends on time", cal_busy, 0);
        chk(cal_done == 1'b1, "R11 done raised", cal_done, 1);
    endtask

    task automatic do_conv(input int raw, input logic [2*M-1:0] swv, input string req);
        int cacc, ex;
        cacc = 0;
        for (int j = 0; j < M; j++) begin
            if (swv[2*j +: 2] == 2'b10) cacc += 2 * exp_eh[j];
            else if (swv[2*j +: 2] == 2'b01) cacc += exp_eh[j];
        end
        ex = raw - ((cacc + 2) >>> 2);
        if (ex < 0) ex = 0;
        if (ex > (1 << RAW_W) - 1) ex = (1 << RAW_W) - 1;
        @(negedge clk);
        conv_valid = 1'b1;
        conv_raw   = RAW_W'(raw);
        conv_sw    = swv;
        @(posedge clk);
        @(negedge clk);
        conv_valid = 1'b0;
        chk(out_valid == 1'b1, {req, " valid"}, out_valid, 1);
        chk(int'(out_data) == ex, {req, " data"}, out_data, ex);
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cal_busy == 1'b0, "R1 busy at reset", cal_busy, 0);
        chk(cal_done == 1'b0, "R1 done at reset", cal_done, 0);
        chk(out_valid == 1'b0, "R1 valid at reset", out_valid, 0);
        chk(dac_sw == {N_CAP{2'b01}}, "R1 idle codes", dac_sw, {N_CAP{2'b01}});
        rst_n = 1'b1;
        for (int j = 0; j < M; j++) exp_eh[j] = 0;
        do_conv(1000, 8'b10101010, "R1 zero terms");
    endtask

    task automatic test_cal_a();
        tr[3] = '{1, 0, -1};
        tr[2] = '{0, 1, 1};
        tr[1] = '{-1, 0, 0};
        tr[0] = '{0, 0, 1};
        run_cal(1'b0);
        repeat (4) @(negedge clk);
        chk(cal_done == 1'b1, "R11 done held", cal_done, 1);
        for (int j = 0; j < M; j++) begin
            logic [2*M-1:0] s;
            s = '0;
            s[2*j +: 2] = 2'b10;
            do_conv(2048, s, "R7 single term");
        end
    endtask

    task automatic test_weights();
        do_conv(1500, 8'b10101010, "R8 all reference");
        do_conv(1500, 8'b01010101, "R8 all common mode");
        do_conv(1500, 8'b00000000, "R8 all ground");
        do_conv(777,  8'b10010010, "R8 mixed");
        do_conv(0,    8'b10000000, "R9 saturate low");
        do_conv(4095, 8'b00001000, "R9 saturate high");
    endtask

    task automatic test_cal_b();
        tr[3] = '{-1, -1, 1};
        tr[2] = '{2, 1, -1};
        tr[1] = '{1, 1, 1};
        tr[0] = '{0, -1, 2};
        run_cal(1'b1);
        do_conv(2000, 8'b10011001, "R7 second run");
        do_conv(2000, 8'b01100110, "R8 second run");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        report();
        $finish;
    end

    initial begin
        test_reset();
        test_cal_a();
        test_weights();
        test_cal_b();
        report();
        $finish;
    end
endmodule